// File: doc/BRIEF.md
# GPIO Output Data and Drive-Enable Register Bank

This block keeps the output data bit and the output-enable bit for up to 64 general-purpose pins (50 by default). Each pin has a small configuration entry. A 3-bit function select in that entry gates software writes: only pins whose select equals 3 accept changes. A 2-bit output mode decides how the pad is driven. The block turns the data bit, the enable bit and the mode into a per-pin drive value and drive enable for the pad ring.

Software uses a simple register port with an address, write strobe, write data, read strobe and read data. The data and enable states are each split into two 32-bit words. For both states there is a direct-write address, a write-one-to-set alias and a write-one-to-clear alias, so single bits can be changed without a read-modify-write. A toggle is done in software by reading the data word and writing it back inverted. If a write would change a pin that is not in GPIO function, that pin keeps its state and an error pulse is raised.

Top module: `gpo_bank`

## Requirements
- R1: After a synchronous active-low reset, every data bit, enable bit, function select and output mode is zero, so no pad is driven and every pad value is 0.
- R2: Pin p is held in word p/32 at bit p%32. Address bit 0 selects the word. Register addresses are: data 0x00/0x01, data set 0x02/0x03, data clear 0x04/0x05, enable 0x06/0x07, enable set 0x08/0x09, enable clear 0x0A/0x0B, input level 0x0C/0x0D. Bits for pin numbers at or above NPINS are never stored and read as zero.
- R3: A direct data write replaces the word. A 1 written to a data set alias bit makes that bit 1, and a 1 written to a data clear alias bit makes it 0. Bits written as 0 through an alias keep their value.
- R4: Enable writes (direct, set, clear) change only the bits of pins whose output mode is 3 (tristate). Other enable bits are left unchanged, and this raises no error.
- R5: A data or enable write that would change the bit of a pin whose function select is not 3 leaves that bit unchanged. wr_err is then 1 for exactly the one cycle that follows the write's clock edge. A write that changes nothing, or only changes GPIO-function pins, leaves wr_err at 0.
- R6: pad_out equals the data bit. pad_oe depends on the mode: it is always 0 in mode 0 (off), always 1 in mode 1 (push-pull), the inverse of the data bit in mode 2 (open-drain), and equal to the enable bit in mode 3 (tristate).
- R7: The configuration of pin p is at address 0x80+p. The function select is in bits [2:0] and the mode is in bits [5:4]. It can be written at any time, and it reads back with all other bits zero.
- R8: rdata takes the addressed value at the clock edge that samples rd_en and holds it until the next read. Reading 0x0C/0x0D returns the current pad_in levels.
- R9: A toggle done as a read of a data word followed by a direct write of its inverse flips the selected bits of GPIO-function pins.
- R10: Alias addresses, unmapped addresses and configuration addresses at or above 0x80+NPINS read as zero. Writes to unmapped addresses change no state and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, registered |
| wr_err | output | 1 | One-cycle pulse: a write was refused on a non-GPIO pin |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Per-pin drive value |
| pad_oe | output | NPINS | Per-pin drive enable |

## Verification
A wrong bit in the data or enable state shows up on pad_out or pad_oe in the cycle right after the faulty write. The bench therefore compares every pad against its model after every write, and does not wait for a later readback. A wrong mode or function-select entry does not show on the pads until it affects something. For a mode, that is the drive enable of a pin whose data or enable bit makes the modes differ. For a function select, it is the next write that tries to change that pin, which shows as a missing or extra wr_err pulse. For this reason the random phase mixes configuration changes with alias writes, and reads entries back through the 0x80 window.

// File: rtl/gpo_pkg.sv
// Package: shared constants, register codes and helpers for the GPIO
// output bank. Assumes at most two 32-bit words of pins (NPINS <= 64).
package gpo_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;
    localparam int NWORDS = 2;
    localparam int PAD_W  = NWORDS * REG_W;
    localparam int FSEL_W = 3;
    localparam int MODE_W = 2;

    localparam logic [FSEL_W-1:0] FSEL_GPIO = 3'd3;

    // register kind codes, taken from address bits [4:1]
    localparam logic [3:0] K_DATA = 4'd0;
    localparam logic [3:0] K_DSET = 4'd1;
    localparam logic [3:0] K_DCLR = 4'd2;
    localparam logic [3:0] K_EN   = 4'd3;
    localparam logic [3:0] K_ESET = 4'd4;
    localparam logic [3:0] K_ECLR = 4'd5;
    localparam logic [3:0] K_IN   = 4'd6;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF  = 2'd0,
        MODE_PUSH = 2'd1,
        MODE_OPEN = 2'd2,
        MODE_TRI  = 2'd3
    } out_mode_e;

    // Drive enable of one pad from its mode, data bit and enable bit.
    function automatic logic pad_drive_en(input logic [MODE_W-1:0] mode,
                                          input logic d, input logic e);
        logic r;
        case (mode)
            MODE_OFF:  r = 1'b0;
            MODE_PUSH: r = 1'b1;
            MODE_OPEN: r = ~d;
            default:   r = e;
        endcase
        return r;
    endfunction

    // Packs a pin configuration into its readback word.
    function automatic logic [REG_W-1:0] cfg_word(input logic [FSEL_W-1:0] f,
                                                  input logic [MODE_W-1:0] m);
        logic [REG_W-1:0] w;
        w      = '0;
        w[2:0] = f;
        w[5:4] = m;
        return w;
    endfunction
endpackage

// File: rtl/gpo_cfg_bank.sv
// Module: per-pin configuration storage (function select and output mode).
// Assumes the pin index arrives already decoded from the address; an index
// at or above NPINS matches no entry and the write is dropped.
module gpo_cfg_bank
    import gpo_pkg::*;
#(
    parameter int NPINS = 50,
    parameter int PIN_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [PIN_W-1:0]        cfg_pin,
    input  logic [REG_W-1:0]        cfg_wdata,
    output logic [FSEL_W*NPINS-1:0] fsel_vec,
    output logic [MODE_W*NPINS-1:0] mode_vec
);
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_wdata[REG_W-1:6], cfg_wdata[3]};

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [FSEL_W-1:0] fsel_q;
        logic [MODE_W-1:0] mode_q;

        // Load this pin's entry when the write targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fsel_q <= '0;
                mode_q <= '0;
            end else if (cfg_we && (cfg_pin == PIN_W'(p))) begin
                fsel_q <= cfg_wdata[2:0];
                mode_q <= cfg_wdata[5:4];
            end
        end

        assign fsel_vec[FSEL_W*p +: FSEL_W] = fsel_q;
        assign mode_vec[MODE_W*p +: MODE_W] = mode_q;
    end
endmodule

// File: rtl/gpo_word_reg.sv
// Module: one 32-bit state word with direct, set and clear write paths.
// A bit changes only where accept is 1. A would-be change on a bit whose
// gpio_ok is 0 is reported on refused. Bits at or above NVALID are absent.
// Same-cycle strobes resolve as clear over set over direct value.
module gpo_word_reg #(
    parameter int WIDTH  = 32,
    parameter int NVALID = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_we,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] accept,
    input  logic [WIDTH-1:0] gpio_ok,
    output logic [WIDTH-1:0] q,
    output logic             refused
);
    localparam logic [WIDTH-1:0] VMASK =
        (NVALID >= WIDTH) ? {WIDTH{1'b1}} :
        (NVALID <= 0)     ? {WIDTH{1'b0}} :
                            ((WIDTH'(1) << NVALID) - WIDTH'(1));

    logic [WIDTH-1:0] want, attempt, take, nxt;

    // Work out the requested value and which requested changes are taken.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            want[i] = q[i];
            if (dir_we)             want[i] = wdata[i];
            if (set_we && wdata[i]) want[i] = 1'b1;
            if (clr_we && wdata[i]) want[i] = 1'b0;
        end
        attempt = (want ^ q) & VMASK;
        take    = attempt & accept;
        nxt     = (q & ~take) | (want & take);
        refused = |(attempt & ~gpio_ok);
    end

    // Hold the word.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt & VMASK;
    end
endmodule

// File: rtl/gpo_drive.sv
// Module: turns each pin's mode, data bit and enable bit into a pad drive
// enable. Purely combinational.
module gpo_drive
    import gpo_pkg::*;
#(
    parameter int NPINS = 50
) (
    input  logic [MODE_W*NPINS-1:0] mode_vec,
    input  logic [NPINS-1:0]        data,
    input  logic [NPINS-1:0]        en,
    output logic [NPINS-1:0]        pad_oe
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pad
        assign pad_oe[p] = pad_drive_en(mode_vec[MODE_W*p +: MODE_W], data[p], en[p]);
    end
endmodule

// File: rtl/gpo_read_port.sv
// Module: read decode and registered read data. rdata changes only on a
// cycle with rd_en. Aliases and unmapped addresses read as zero.
module gpo_read_port
    import gpo_pkg::*;
#(
    parameter int NPINS = 50
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [PAD_W-1:0]        data_q,
    input  logic [PAD_W-1:0]        en_q,
    input  logic [PAD_W-1:0]        in_pad,
    input  logic [FSEL_W*NPINS-1:0] fsel_vec,
    input  logic [MODE_W*NPINS-1:0] mode_vec,
    output logic [REG_W-1:0]        rdata
);
    localparam int PIN_W = ADDR_W - 1;

    logic [PAD_W-1:0] view;
    logic [REG_W-1:0] rd_val;

    // Select the addressed value.
    always_comb begin
        case (addr[4:1])
            K_DATA:  view = data_q;
            K_EN:    view = en_q;
            K_IN:    view = in_pad;
            default: view = '0;
        endcase
        rd_val = '0;
        if (addr[ADDR_W-1]) begin
            for (int p = 0; p < NPINS; p++) begin
                if (addr[PIN_W-1:0] == PIN_W'(p))
                    rd_val = cfg_word(fsel_vec[FSEL_W*p +: FSEL_W],
                                      mode_vec[MODE_W*p +: MODE_W]);
            end
        end else if (addr[ADDR_W-2:5] == '0) begin
            rd_val = addr[0] ? view[PAD_W-1:REG_W] : view[REG_W-1:0];
        end
    end

    // Capture read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end
endmodule

// File: rtl/gpo_bank.sv
// Module: top of the GPIO output bank. It decodes the register port into
// configuration, data and enable writes, gates them by function select and
// mode, and drives the pads. Assumes 1 <= NPINS <= 64.
module gpo_bank
    import gpo_pkg::*;
#(
    parameter int NPINS = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rdata,
    output logic              wr_err,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);
    localparam int PIN_W = ADDR_W - 1;

    logic [FSEL_W*NPINS-1:0] fsel_vec;
    logic [MODE_W*NPINS-1:0] mode_vec;
    logic [PAD_W-1:0]        gpio_ok, tri_ok, data_q, en_q, in_pad;
    logic [NWORDS-1:0]       refused_d, refused_e;
    logic                    reg_space, cfg_we;
    logic [3:0]              kind;

    assign reg_space = wr_en && (addr[ADDR_W-1:5] == '0);
    assign kind      = addr[4:1];
    assign cfg_we    = wr_en && addr[ADDR_W-1];

    gpo_cfg_bank #(.NPINS(NPINS), .PIN_W(PIN_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_pin   (addr[PIN_W-1:0]),
        .cfg_wdata (wdata),
        .fsel_vec  (fsel_vec),
        .mode_vec  (mode_vec)
    );

    // Per-pin write permission masks, padded out to the full word span.
    always_comb begin
        gpio_ok = '0;
        tri_ok  = '0;
        in_pad  = '0;
        for (int p = 0; p < NPINS; p++) begin
            gpio_ok[p] = (fsel_vec[FSEL_W*p +: FSEL_W] == FSEL_GPIO);
            tri_ok[p]  = gpio_ok[p] && (mode_vec[MODE_W*p +: MODE_W] == MODE_TRI);
            in_pad[p]  = pad_in[p];
        end
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        localparam int NV_RAW = NPINS - w * REG_W;
        localparam int NV     = (NV_RAW > REG_W) ? REG_W : ((NV_RAW < 0) ? 0 : NV_RAW);
        logic hit;
        assign hit = reg_space && (addr[0] == 1'(w));

        gpo_word_reg #(.WIDTH(REG_W), .NVALID(NV)) u_data (
            .clk     (clk),
            .rst_n   (rst_n),
            .dir_we  (hit && (kind == K_DATA)),
            .set_we  (hit && (kind == K_DSET)),
            .clr_we  (hit && (kind == K_DCLR)),
            .wdata   (wdata),
            .accept  (gpio_ok[REG_W*w +: REG_W]),
            .gpio_ok (gpio_ok[REG_W*w +: REG_W]),
            .q       (data_q[REG_W*w +: REG_W]),
            .refused (refused_d[w])
        );

        gpo_word_reg #(.WIDTH(REG_W), .NVALID(NV)) u_en (
            .clk     (clk),
            .rst_n   (rst_n),
            .dir_we  (hit && (kind == K_EN)),
            .set_we  (hit && (kind == K_ESET)),
            .clr_we  (hit && (kind == K_ECLR)),
            .wdata   (wdata),
            .accept  (tri_ok[REG_W*w +: REG_W]),
            .gpio_ok (gpio_ok[REG_W*w +: REG_W]),
            .q       (en_q[REG_W*w +: REG_W]),
            .refused (refused_e[w])
        );
    end

    // Pulse the error flag for one cycle after a refused write.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= |{refused_d, refused_e};
    end

    gpo_drive #(.NPINS(NPINS)) u_drive (
        .mode_vec (mode_vec),
        .data     (data_q[NPINS-1:0]),
        .en       (en_q[NPINS-1:0]),
        .pad_oe   (pad_oe)
    );

    assign pad_out = data_q[NPINS-1:0];

    gpo_read_port #(.NPINS(NPINS)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .addr     (addr),
        .data_q   (data_q),
        .en_q     (en_q),
        .in_pad   (in_pad),
        .fsel_vec (fsel_vec),
        .mode_vec (mode_vec),
        .rdata    (rdata)
    );
endmodule

// File: rtl/gpo_bank_chk.sv
// Module: assertion checker for gpo_bank, attached by bind. Checks how the
// pads relate to the configured modes, and when errors, state and read
// data may change.
module gpo_bank_chk
    import gpo_pkg::*;
#(
    parameter int NPINS = 50
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    rd_en,
    input logic                    wr_err,
    input logic [REG_W-1:0]        rdata,
    input logic [NPINS-1:0]        pad_out,
    input logic [NPINS-1:0]        pad_oe,
    input logic [MODE_W*NPINS-1:0] mode_vec,
    input logic [PAD_W-1:0]        data_q
);
    logic [NPINS-1:0] off_m, push_m, open_m;

    // Sort pins by configured mode.
    always_comb begin
        for (int p = 0; p < NPINS; p++) begin
            off_m[p]  = (mode_vec[MODE_W*p +: MODE_W] == MODE_OFF);
            push_m[p] = (mode_vec[MODE_W*p +: MODE_W] == MODE_PUSH);
            open_m[p] = (mode_vec[MODE_W*p +: MODE_W] == MODE_OPEN);
        end
    end

    // R6
    off_never_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & off_m) == '0);
    // R6
    push_always_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_m & ~pad_oe) == '0);
    // R6
    open_drain_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_m & pad_oe & pad_out) == '0);
    // R5
    err_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en));
    // R3
    data_stable_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(data_q));
    // R8
    rdata_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind gpo_bank gpo_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wr_err   (wr_err),
    .rdata    (rdata),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .mode_vec (mode_vec),
    .data_q   (data_q)
);

// File: tb/tb_gpo_bank.sv
`timescale 1ns/1ps
module tb_gpo_bank;
    import gpo_pkg::*;
    localparam int NPINS = 50;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        addr = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              wr_err;
    logic [NPINS-1:0]  pad_in = '0;
    logic [NPINS-1:0]  pad_out;
    logic [NPINS-1:0]  pad_oe;

    int n_checks = 0;
    int n_errs   = 0;

    logic [63:0] m_data = '0;
    logic [63:0] m_en   = '0;
    logic [63:0] m_in   = '0;
    logic [2:0]  m_fsel [64];
    logic [1:0]  m_mode [64];

    always #10 clk = ~clk;

    gpo_bank #(.NPINS(NPINS)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .wr_err(wr_err), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_oe(input int p);
        case (m_mode[p])
            2'd0:    return 1'b0;
            2'd1:    return 1'b1;
            2'd2:    return ~m_data[p];
            default: return m_en[p];
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [63:0] v;
        int k;
        if (a[7]) begin
            if (int'(a[6:0]) < NPINS) return cfg_word(m_fsel[a[6:0]], m_mode[a[6:0]]);
            return '0;
        end
        if (a[6:5] != 2'b00) return '0;
        k = int'(a[4:1]);
        if (k == 0)      v = m_data;
        else if (k == 3) v = m_en;
        else if (k == 6) v = m_in;
        else             v = '0;
        return a[0] ? v[63:32] : v[31:0];
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d, output logic err);
        int  k, w, p;
        logic cur, want, isen;
        err = 1'b0;
        if (a[7]) begin
            if (int'(a[6:0]) < NPINS) begin
                m_fsel[a[6:0]] = d[2:0];
                m_mode[a[6:0]] = d[5:4];
            end
            return;
        end
        if (a[6:5] != 2'b00) return;
        k = int'(a[4:1]);
        if (k > 5) return;
        w = int'(a[0]);
        isen = (k >= 3);
        for (int b = 0; b < 32; b++) begin
            p = w * 32 + b;
            if (p >= NPINS) continue;
            cur = isen ? m_en[p] : m_data[p];
            case (k % 3)
                0:       want = d[b];
                1:       want = d[b] ? 1'b1 : cur;
                default: want = d[b] ? 1'b0 : cur;
            endcase
            if (want != cur) begin
                if (m_fsel[p] != 3'd3) err = 1'b1;
                else if (!isen) m_data[p] = want;
                else if (m_mode[p] == 2'd3) m_en[p] = want;
            end
        end
    endtask

    task automatic check_pads();
        logic [NPINS-1:0] eo;
        for (int p = 0; p < NPINS; p++) eo[p] = exp_oe(p);
        chk("R6 pad_out", 64'(pad_out), 64'(m_data[NPINS-1:0]));
        chk("R6 pad_oe", 64'(pad_oe), 64'(eo));
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input string tag);
        logic e;
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d, e);
        chk({tag, " R5 wr_err"}, 64'(wr_err), 64'(e));
        check_pads();
    endtask

    task automatic do_read(input logic [7:0] a, input string tag, output logic [31:0] r);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        r = rdata;
        chk(tag, 64'(r), 64'(model_read(a)));
    endtask

    task automatic new_inputs();
        logic [63:0] v;
        v = {$urandom, $urandom};
        pad_in = v[NPINS-1:0];
        m_in = '0;
        m_in[NPINS-1:0] = v[NPINS-1:0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  a;
        int sel;
        for (int p = 0; p < 64; p++) begin
            m_fsel[p] = '0;
            m_mode[p] = '0;
        end
        r = $urandom(32'd7351);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe", 64'(pad_oe), 64'd0);
        chk("R1 pad_out", 64'(pad_out), 64'd0);
        do_read(8'h00, "R1 data0", r);
        do_read(8'h01, "R1 data1", r);
        do_read(8'h06, "R1 en0", r);
        do_read(8'h07, "R1 en1", r);
        do_read(8'h80, "R1 cfg0", r);
        do_read(8'h80 + 8'(NPINS - 1), "R1 cfg last", r);

        // R7 configure all pins as GPIO with rotating modes
        for (int p = 0; p < NPINS; p++) do_write(8'h80 + 8'(p), cfg_word(3'd3, 2'(p % 4)), "R7");
        do_read(8'h86, "R7 cfg6", r);
        do_read(8'h80 + 8'(NPINS - 1), "R7 cfg last", r);

        // R2 word split and absent upper bits
        do_write(8'h01, 32'hFFFF_FFFF, "R2");
        do_read(8'h01, "R2 data1 upper bits zero", r);
        chk("R2 data1 literal", 64'(r), 64'h3FFFF);

        // R3 direct, set and clear on data
        do_write(8'h00, 32'hA5A5_0F0F, "R3");
        do_read(8'h00, "R3 direct", r);
        do_write(8'h02, 32'h0000_00F0, "R3");
        do_read(8'h00, "R3 set", r);
        do_write(8'h04, 32'h0000_0F00, "R3");
        do_read(8'h00, "R3 clear", r);
        chk("R3 literal", 64'(r), 64'hA5A5_00FF);
        do_write(8'h05, 32'h0002_0000, "R3");
        do_read(8'h01, "R3 clear word1", r);

        // R4 enable writes only hit tristate pins
        do_write(8'h08, 32'hFFFF_FFFF, "R4");
        do_read(8'h06, "R4 enable set", r);
        chk("R4 literal", 64'(r), 64'h8888_8888);
        do_write(8'h0A, 32'h0000_0088, "R4");
        do_read(8'h06, "R4 enable clear", r);
        do_write(8'h09, 32'h0003_FFFF, "R4");
        do_read(8'h07, "R4 enable set word1", r);
        do_write(8'h06, 32'h0000_0000, "R4");
        do_read(8'h06, "R4 enable direct", r);

        // R5 refused write on a non-GPIO pin
        do_write(8'h85, cfg_word(3'd2, 2'd1), "R7");
        do_write(8'h04, 32'h0000_0020, "R5");
        do_read(8'h00, "R5 bit kept", r);
        chk("R5 bit5 kept", 64'(r[5]), 64'd1);
        do_write(8'h02, 32'h0000_0020, "R5 no change");

        // R9 toggle by read-modify-write
        do_read(8'h00, "R9 read", r);
        do_write(8'h00, r ^ 32'h0000_FFFF, "R9");
        do_read(8'h00, "R9 toggled", r);

        // R8 input view
        new_inputs();
        do_read(8'h0C, "R8 input0", r);
        do_read(8'h0D, "R8 input1", r);

        // R10 aliases and unmapped space
        do_read(8'h03, "R10 alias read", r);
        do_read(8'h0E, "R10 unmapped", r);
        do_read(8'h20, "R10 unmapped high", r);
        do_read(8'h80 + 8'(NPINS), "R10 cfg beyond", r);
        do_write(8'h0E, 32'hFFFF_FFFF, "R10");
        do_write(8'h24, 32'hFFFF_FFFF, "R10");
        do_read(8'h00, "R10 data unchanged", r);

        // random phase
        for (int i = 0; i < 600; i++) begin
            sel = int'($urandom % 10);
            if (sel < 2) begin
                a = 8'h80 + 8'($urandom % NPINS);
                do_write(a, cfg_word(($urandom % 4 == 0) ? 3'($urandom) : 3'd3, 2'($urandom)), "R7");
            end else if (sel < 8) begin
                a = {3'b000, 4'($urandom % 6), 1'($urandom)};
                do_write(a, $urandom, "R3");
            end else begin
                new_inputs();
                if ($urandom % 2 == 0) a = 8'($urandom % 16);
                else a = 8'h80 + 8'($urandom % 64);
                do_read(a, "R8 random read", r);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule